// File: doc/BRIEF.md
# Gated Infrared Carrier Generator

This block turns a prescaled clock of roughly 2.133 MHz into an infrared transmit carrier near 38.1 kHz. A 6-bit synchronous counter steps through 56 states, from 4 up to 59, and then reloads to 4. The carrier is high for the upper half of those states and low for the lower half, so it divides the clock by 56 with an exact 50% duty cycle. The carrier comes from a register and cannot glitch.

A microcontroller switches the carrier on and off with a transmit-enable input. The block samples that input only at a period boundary. A burst therefore always starts and ends with whole carrier cycles, and no cycle is ever cut short. Once per period the block gives the controller a one-cycle interrupt pulse. The pulse comes whatever the state of transmit enable, so firmware can pace its bursts in whole carrier periods.

Top module: `ircg_carrier_top`

## Requirements
- R1: While reset is asserted, ir_led and irq are low and the count is 4. The first irq pulse after reset release appears in the 56th clock cycle after release, and the gate starts closed.
- R2: irq pulses are spaced exactly 56 clock cycles apart.
- R3: irq is high for exactly one clock cycle at a time.
- R4: If the gate was open at the start of a period, ir_led is low for the first 28 cycles of that period and high for the last 28. The period starts in the cycle where irq is high.
- R5: tx_en is sampled only at the clock edge that starts a period, which is the edge that raises irq. A change of tx_en at any other time has no effect on ir_led until the next period.
- R6: If the gate was closed at the start of a period, ir_led stays low for the whole period. irq keeps pulsing whatever the value of tx_en.
- R7: Every high pulse on ir_led lasts exactly 28 cycles. It starts at count 32 and ends when the count reloads to 4.
- R8: ir_led is never high in a cycle where irq is high, including the cycle in which the gate changes state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the controller, sampled at period boundaries |
| ir_led | output | 1 | Gated 50% duty carrier to the LED driver |
| irq | output | 1 | One-cycle pulse at the start of each carrier period |

## Verification
Three things happen at the same clock edge: the counter reloads, the interrupt pulse rises, and the transmit gate is sampled. The carrier is also falling at that edge. The bench provokes this overlap by changing tx_en a few cycles before the boundary, and again in the middle of the period, across a sequence of periods. In each period it checks that irq is high exactly in the first cycle. It also checks that ir_led is low in that cycle and that the new gate state shows only in the upper half of the period that just began.

// File: rtl/ircg_pkg.sv
package ircg_pkg;

   // First count of the high half of a period from lo up to hi.
   function automatic int half_point(input int lo, input int hi);
      return lo + (hi - lo + 1) / 2;
   endfunction

   // Number of states in one period.
   function automatic int span(input int lo, input int hi);
      return hi - lo + 1;
   endfunction

endpackage

// File: rtl/ircg_period_ctr.sv
module ircg_period_ctr #(
   parameter int CNT_W  = 6,
   parameter int CNT_LO = 4,
   parameter int CNT_HI = 59
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             wrap_o,
   output logic             irq_o
);

   localparam logic [CNT_W-1:0] LO_V = CNT_W'(CNT_LO);
   localparam logic [CNT_W-1:0] HI_V = CNT_W'(CNT_HI);
   localparam bit FULL_RANGE = (CNT_LO == 0) && (CNT_HI == (1 << CNT_W) - 1);

   initial begin
      lo_below_hi_chk : assert (CNT_HI > CNT_LO)
         else $fatal(1, "ircg_period_ctr: top count must exceed base count");
      hi_fits_chk : assert (CNT_HI < (1 << CNT_W))
         else $fatal(1, "ircg_period_ctr: top count does not fit in CNT_W bits");
      even_span_chk : assert ((ircg_pkg::span(CNT_LO, CNT_HI) % 2) == 0)
         else $fatal(1, "ircg_period_ctr: period length must be even");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             at_top;

   assign at_top = (cnt_q == HI_V);

   generate
      if (FULL_RANGE) begin : g_natural_wrap
         assign cnt_nxt_o = cnt_q + 1'b1;
      end else begin : g_reload_wrap
         assign cnt_nxt_o = at_top ? LO_V : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= LO_V;
         irq_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt_o;
         irq_q <= at_top;
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = at_top;
   assign irq_o  = irq_q;

   // R2
   cnt_in_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= LO_V) && (cnt_q <= HI_V));

   // R2
   reload_after_top_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == HI_V) |=> (cnt_q == LO_V));

   // R3
   irq_one_cycle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R2
   irq_at_base_chk : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (cnt_q == LO_V));

endmodule

// File: rtl/ircg_carrier_gate.sv
module ircg_carrier_gate #(
   parameter int CNT_W  = 6,
   parameter int CNT_LO = 4,
   parameter int CNT_HI = 59
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   output logic             led_o
);

   localparam int               MID  = ircg_pkg::half_point(CNT_LO, CNT_HI);
   localparam logic [CNT_W-1:0] MID_V = CNT_W'(MID);
   localparam logic [CNT_W-1:0] LO_V  = CNT_W'(CNT_LO);

   logic gate_q;
   logic gate_nxt;
   logic led_q;

   assign gate_nxt = wrap_i ? tx_en_i : gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         led_q  <= 1'b0;
      end else begin
         gate_q <= gate_nxt;
         led_q  <= gate_nxt && (cnt_nxt_i >= MID_V);
      end
   end

   assign led_o = led_q;

   // R5
   gate_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> $stable(gate_q));

   // R7
   led_rise_at_mid_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(led_q) |-> (cnt_i == MID_V));

   // R7
   led_fall_at_base_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(led_q) |-> (cnt_i == LO_V));

   // R4
   led_low_half_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i < MID_V) |-> !led_q);

endmodule

// File: rtl/ircg_carrier_top.sv
module ircg_carrier_top #(
   parameter int CNT_W  = 6,
   parameter int CNT_LO = 4,
   parameter int CNT_HI = 59
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   output logic ir_led,
   output logic irq
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             wrap;

   ircg_period_ctr #(
      .CNT_W (CNT_W),
      .CNT_LO(CNT_LO),
      .CNT_HI(CNT_HI)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_o    (cnt),
      .cnt_nxt_o(cnt_nxt),
      .wrap_o   (wrap),
      .irq_o    (irq)
   );

   ircg_carrier_gate #(
      .CNT_W (CNT_W),
      .CNT_LO(CNT_LO),
      .CNT_HI(CNT_HI)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en_i  (tx_en),
      .wrap_i   (wrap),
      .cnt_i    (cnt),
      .cnt_nxt_i(cnt_nxt),
      .led_o    (ir_led)
   );

   // R8
   no_led_in_irq_chk : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !ir_led);

endmodule

// File: tb/tb_ircg_carrier_top.sv
module tb_ircg_carrier_top;

   localparam int PERIOD = 56;
   localparam int HALF   = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic ir_led;
   logic irq;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   ircg_carrier_top dut (
      .clk   (clk),
      .rst_n (rst_n),
      .tx_en (tx_en),
      .ir_led(ir_led),
      .irq   (irq)
   );

   // Vector fields: [7] gate state for the period, [6] toggle tx_en mid-period,
   // [5:0] expected number of high ir_led cycles in the period.
   localparam int NV = 8;
   localparam logic [7:0] VEC [NV] = '{
      {1'b1, 1'b0, 6'd28},
      {1'b1, 1'b1, 6'd28},
      {1'b0, 1'b0, 6'd0},
      {1'b0, 1'b1, 6'd0},
      {1'b1, 1'b0, 6'd28},
      {1'b0, 1'b0, 6'd0},
      {1'b1, 1'b1, 6'd28},
      {1'b1, 1'b0, 6'd28}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_irq();
      int guard = 0;
      while (irq !== 1'b1 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk("R2 irq seen", irq, 1'b1);
   endtask

   task automatic count_to_irq(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (irq !== 1'b1 && n < 200);
   endtask

   initial begin
      #(200000 * 10);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int n;
      int highs;
      int runs;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 led in reset", ir_led, 1'b0);
      chk("R1 irq in reset", irq, 1'b0);
      tx_en = VEC[0][7];
      rst_n = 1'b1;
      count_to_irq(n);
      chk_int("R1 first irq cycle", n, PERIOD);

      // Table walk: R2 R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         wait_irq();
         highs = 0;
         runs  = 0;
         for (int o = 0; o < PERIOD; o++) begin
            // R4 R6 duty and gating, expected high count from the table
            chk("R4/R6 led level", ir_led, (o >= PERIOD - int'(VEC[v][5:0])));
            // R3 single pulse, R2 spacing
            chk("R3 irq position", irq, (o == 0));
            // R8 coincidence of boundary and carrier
            if (o == 0) chk("R8 led low in irq cycle", ir_led, 1'b0);
            if (ir_led === 1'b1) begin
               highs++;
               if (o == 0 || ir_led !== 1'b1) runs++;
            end
            if (o == 10 && VEC[v][6]) tx_en = ~tx_en;     // R5 mid-period change
            if (o == 50) tx_en = (v + 1 < NV) ? VEC[v+1][7] : 1'b1;
            @(negedge clk);
         end
         // R7 whole pulse length
         chk_int("R7 high cycles", highs, int'(VEC[v][5:0]));
      end

      // R5 change one cycle before boundary is taken, one cycle after is not
      wait_irq();
      tx_en = 1'b1;
      repeat (PERIOD - 1) @(negedge clk);
      tx_en = 1'b0;
      chk("R5 irq next edge pending", irq, 1'b0);
      @(negedge clk);
      chk("R2 boundary", irq, 1'b1);
      tx_en = 1'b1;
      repeat (HALF) @(negedge clk);
      chk("R5 late enable ignored", ir_led, 1'b0);
      repeat (HALF) @(negedge clk);
      chk("R6 irq with gate closed", irq, 1'b1);
      repeat (HALF) @(negedge clk);
      chk("R4 enabled next period", ir_led, 1'b1);

      // R1 reset in the middle of a high half
      rst_n = 1'b0;
      #1;
      chk("R1 led cleared by reset", ir_led, 1'b0);
      chk("R1 irq cleared by reset", irq, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      highs = 0;
      for (int k = 0; k < PERIOD - 1; k++) begin
         @(negedge clk);
         if (ir_led === 1'b1) highs++;
      end
      chk_int("R1 gate closed after reset", highs, 0);
      @(negedge clk);
      chk("R1 first irq after reset", irq, 1'b1);
      repeat (HALF) @(negedge clk);
      chk("R4 carrier after reset", ir_led, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule